// File: doc/BRIEF.md
# Link Disconnect Sequencer

This controller carries out, on behalf of firmware, the handshake that lets every device on a point-to-point link pick up new width and frequency settings without a full reset. Firmware issues a non-posted write to a trigger register. The controller answers by sending a clock-stop assertion message that carries the write's unit identifier and a link-reinitialization action code. Only after that message has gone out does it release the write's completion.

The controller then waits for a stop-grant message whose action code matches the link-reinitialization reason. Once one arrives, it waits a programmable settling time so that the grant can reach the other devices. It then pulls the active-low link-stop output low for a programmable hold time. After it releases link-stop, it sends a clock-stop deassertion message and returns to idle.

Firmware programs both times through the same write port. All messages use valid/ready handshakes. A message counts as transferred only in a cycle where valid and ready are both high.

Top module: `lnk_dsc_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `link_stop_n` is 1, `tx_valid` is 0 and `rsp_valid` is 0.
- R2: A write to address 0 with data bit 0 set, made while idle, raises `busy` in the next cycle. In that same cycle the controller offers a clock-stop assertion message: `tx_kind` = 1, `tx_uid` = the write's `wr_uid`, `tx_code` = `CODE_REINIT`.
- R3: `rsp_valid` stays 0 until the clock-stop assertion message has been transferred. It rises in the cycle after that transfer, with `rsp_uid` equal to the trigger write's `wr_uid`. It stays high until `rsp_ready` is seen.
- R4: After the completion has been taken, only a received message with `rx_kind` = 3 and `rx_code` = `CODE_REINIT` counts as a grant. A stop-grant message with any other code leaves `link_stop_n` high, and the controller keeps waiting.
- R5: `link_stop_n` goes low exactly D+1 cycles after the cycle in which the grant is accepted. D is the settle count held in address 1.
- R6: `link_stop_n` stays low for exactly H+1 cycles. H is the hold count held in address 2.
- R7: The controller offers the clock-stop deassertion message (`tx_kind` = 2, same uid and code) only while `link_stop_n` is high, in the first cycle after release. `busy` falls in the cycle after that message is transferred.
- R8: A trigger write made while `busy` is 1, or a write to address 0 with data bit 0 clear, has no effect: no message is offered and no completion is produced.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_kind`, `tx_uid` and `tx_code` hold their values.
- R10: Out of reset, the settle and hold counts equal the parameters `DEF_SETTLE` and `DEF_HOLD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0 trigger, 1 settle, 2 hold) |
| wr_data | input | DATA_W | Write data |
| wr_uid | input | UID_W | Unit identifier of the write |
| rsp_valid | output | 1 | Trigger-write completion pending |
| rsp_ready | input | 1 | Completion accepted |
| rsp_uid | output | UID_W | Unit identifier of the completion |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Outgoing message accepted |
| tx_kind | output | 2 | 1 clock-stop assert, 2 clock-stop deassert |
| tx_uid | output | UID_W | Message unit identifier |
| tx_code | output | CODE_W | Message action code |
| rx_valid | input | 1 | Incoming message valid |
| rx_ready | output | 1 | Always 1; every incoming message is consumed |
| rx_kind | input | 2 | Incoming kind; 3 is stop-grant |
| rx_code | input | CODE_W | Incoming action code |
| link_stop_n | output | 1 | Active-low link-stop |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the controller with an 8-bit count width, a 5-bit uid, an action code of 0xA5, and reset counts of 3 (settle) and 4 (hold). The small counts let it measure the exact settle and hold windows across several programmed values, including the zero counts that give the shortest one-cycle windows. They also let it check the reset-default run and a run with a stalled transmit port, each within a few dozen cycles.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic [1:0] {
    MSG_NONE      = 2'd0,
    MSG_CSTOP_ON  = 2'd1,
    MSG_CSTOP_OFF = 2'd2,
    MSG_GRANT     = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_ON,
    ST_RESP,
    ST_WAIT_GRANT,
    ST_SETTLE,
    ST_HOLD,
    ST_SEND_OFF
  } seq_state_e;

  localparam int unsigned REG_TRIG   = 0;
  localparam int unsigned REG_SETTLE = 1;
  localparam int unsigned REG_HOLD   = 2;
endpackage

// File: rtl/lds_cfg_regs.sv
module lds_cfg_regs
  import lds_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_SETTLE = 16,
  parameter int unsigned DEF_HOLD   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [CNT_W-1:0]  settle_q,
  output logic [CNT_W-1:0]  hold_q,
  output logic              trig
);
  logic settle_en, hold_en;
  logic [CNT_W-1:0] wr_cnt;

  assign wr_cnt    = wr_data[CNT_W-1:0];
  assign settle_en = wr_en && (wr_addr == ADDR_W'(REG_SETTLE));
  assign hold_en   = wr_en && (wr_addr == ADDR_W'(REG_HOLD));
  assign trig      = wr_en && (wr_addr == ADDR_W'(REG_TRIG)) && wr_data[0] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= CNT_W'(DEF_SETTLE);
    end else if (settle_en) begin
      settle_q <= wr_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= CNT_W'(DEF_HOLD);
    end else if (hold_en) begin
      hold_q <= wr_cnt;
    end
  end
endmodule

// File: rtl/lds_delay_cnt.sv
module lds_delay_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || dec;
  assign zero   = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && !zero) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lds_seq_fsm.sv
module lds_seq_fsm
  import lds_pkg::*;
#(
  parameter int unsigned UID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [UID_W-1:0] trig_uid,
  input  logic             tx_ready,
  input  logic             rsp_ready,
  input  logic             grant_ok,
  input  logic             cnt_zero,
  output seq_state_e       state_q,
  output logic [UID_W-1:0] uid_q,
  output logic             load_settle,
  output logic             load_hold,
  output logic             cnt_dec
);
  seq_state_e state_d;
  logic       uid_en;

  assign uid_en = trig && (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    load_settle = 1'b0;
    load_hold   = 1'b0;
    cnt_dec     = 1'b0;
    unique case (state_q)
      ST_IDLE:       if (trig) state_d = ST_SEND_ON;
      ST_SEND_ON:    if (tx_ready) state_d = ST_RESP;
      ST_RESP:       if (rsp_ready) state_d = ST_WAIT_GRANT;
      ST_WAIT_GRANT: if (grant_ok) begin
                       state_d     = ST_SETTLE;
                       load_settle = 1'b1;
                     end
      ST_SETTLE:     if (cnt_zero) begin
                       state_d   = ST_HOLD;
                       load_hold = 1'b1;
                     end else begin
                       cnt_dec = 1'b1;
                     end
      ST_HOLD:       if (cnt_zero) state_d = ST_SEND_OFF;
                     else cnt_dec = 1'b1;
      ST_SEND_OFF:   if (tx_ready) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uid_q <= '0;
    end else if (uid_en) begin
      uid_q <= trig_uid;
    end
  end

  AST_SETTLE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && $past(state_q == ST_WAIT_GRANT)) |-> $past(grant_ok)); // R4
endmodule

// File: rtl/lnk_dsc_ctrl.sv
module lnk_dsc_ctrl
  import lds_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned UID_W       = 5,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned CODE_REINIT = 8'h3C,
  parameter int unsigned DEF_SETTLE  = 16,
  parameter int unsigned DEF_HOLD    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [UID_W-1:0]  wr_uid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [UID_W-1:0]  rsp_uid,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [1:0]        tx_kind,
  output logic [UID_W-1:0]  tx_uid,
  output logic [CODE_W-1:0] tx_code,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [1:0]        rx_kind,
  input  logic [CODE_W-1:0] rx_code,
  output logic              link_stop_n,
  output logic              busy
);
  localparam logic [CODE_W-1:0] REINIT = CODE_W'(CODE_REINIT);

  seq_state_e       state_q;
  logic [UID_W-1:0] uid_q;
  logic [CNT_W-1:0] settle_q, hold_q, load_val;
  logic             trig, grant_ok, load_settle, load_hold, cnt_dec, cnt_zero;

  lds_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .DEF_SETTLE(DEF_SETTLE), .DEF_HOLD(DEF_HOLD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .settle_q(settle_q), .hold_q(hold_q), .trig(trig)
  );

  assign grant_ok = rx_valid && (rx_kind == MSG_GRANT) && (rx_code == REINIT)
                    && (state_q == ST_WAIT_GRANT);

  lds_seq_fsm #(.UID_W(UID_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_uid(wr_uid), .tx_ready(tx_ready),
    .rsp_ready(rsp_ready), .grant_ok(grant_ok), .cnt_zero(cnt_zero), .state_q(state_q),
    .uid_q(uid_q), .load_settle(load_settle), .load_hold(load_hold), .cnt_dec(cnt_dec)
  );

  assign load_val = load_settle ? settle_q : hold_q;

  lds_delay_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_settle || load_hold), .load_val(load_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  assign busy        = (state_q != ST_IDLE);
  assign tx_valid    = (state_q == ST_SEND_ON) || (state_q == ST_SEND_OFF);
  assign tx_kind     = (state_q == ST_SEND_OFF) ? MSG_CSTOP_OFF : MSG_CSTOP_ON;
  assign tx_uid      = uid_q;
  assign tx_code     = REINIT;
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_uid     = uid_q;
  assign rx_ready    = 1'b1;
  assign link_stop_n = (state_q != ST_HOLD);

  AST_RSP_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(tx_valid && tx_ready && tx_kind == MSG_CSTOP_ON)); // R3
  AST_RSP_UID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rsp_uid == $past(tx_uid))); // R3
  AST_STOP_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_stop_n) |-> $past(state_q == ST_SETTLE)); // R5
  AST_OFF_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_kind == MSG_CSTOP_OFF) |-> link_stop_n); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_kind) && $stable(tx_uid))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (link_stop_n && !tx_valid && !rsp_valid)); // R1
endmodule

// File: tb/lnk_dsc_ctrl_test.sv
`timescale 1ns/1ps
module lnk_dsc_ctrl_test;
  localparam int ADDR_W = 4, DATA_W = 32, UID_W = 5, CODE_W = 8, CNT_W = 8;
  localparam int CODE = 8'hA5, DSET = 3, DHOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rsp_ready = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [UID_W-1:0] wr_uid = '0;
  logic [1:0] rx_kind = '0;
  logic [CODE_W-1:0] rx_code = '0;
  logic rsp_valid, tx_valid, rx_ready, link_stop_n, busy;
  logic [UID_W-1:0] rsp_uid, tx_uid;
  logic [1:0] tx_kind;
  logic [CODE_W-1:0] tx_code;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lnk_dsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UID_W(UID_W), .CODE_W(CODE_W),
    .CNT_W(CNT_W), .CODE_REINIT(CODE), .DEF_SETTLE(DSET), .DEF_HOLD(DHOLD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_uid(wr_uid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_uid(rsp_uid),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind), .tx_uid(tx_uid),
    .tx_code(tx_code), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_kind(rx_kind),
    .rx_code(rx_code), .link_stop_n(link_stop_n), .busy(busy));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data, int uid);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data); wr_uid = UID_W'(uid);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_rx(int kind, int code);
    rx_valid = 1'b1; rx_kind = 2'(kind); rx_code = CODE_W'(code);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 link_stop_n", link_stop_n, 1);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_bad_trigger;
    wr(0, 32'h2, 7);
    chk("R8 bit0 clear no msg", tx_valid, 0);
    chk("R8 bit0 clear not busy", busy, 0);
  endtask

  task automatic t_sequence(int uid, int d, int h, int stall);
    int hi, lo;
    wr(0, 1, uid);
    chk("R2 busy", busy, 1);
    chk("R2 tx_valid", tx_valid, 1);
    chk("R2 tx_kind", tx_kind, 1);
    chk("R2 tx_uid", tx_uid, uid);
    chk("R2 tx_code", tx_code, CODE);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R3 no rsp before msg", rsp_valid, 0);
      chk("R9 tx_valid held", tx_valid, 1);
      chk("R9 tx_uid held", tx_uid, uid);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R3 rsp_valid", rsp_valid, 1);
    chk("R3 rsp_uid", rsp_uid, uid);
    @(negedge clk);
    chk("R3 rsp held", rsp_valid, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R3 rsp taken", rsp_valid, 0);
    wr(0, 1, uid ^ 1);
    chk("R8 busy trigger no msg", tx_valid, 0);
    chk("R8 busy trigger no rsp", rsp_valid, 0);
    send_rx(3, CODE ^ 8'hFF);
    repeat (d + 3) begin
      chk("R4 bad code ignored", link_stop_n, 1);
      @(negedge clk);
    end
    send_rx(3, CODE);
    hi = 0;
    while (link_stop_n && hi < 600) begin hi++; @(negedge clk); end
    chk("R5 settle cycles", hi, d + 1);
    lo = 0;
    while (!link_stop_n && lo < 600) begin
      chk("R7 no off msg while stopped", tx_valid, 0);
      lo++; @(negedge clk);
    end
    chk("R6 hold cycles", lo, h + 1);
    chk("R7 off valid", tx_valid, 1);
    chk("R7 off kind", tx_kind, 2);
    chk("R7 off uid", tx_uid, uid);
    chk("R7 still busy", busy, 1);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R7 busy falls", busy, 0);
    chk("R7 tx drops", tx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_trigger();
    // R10: first run uses reset-default counts
    t_sequence(9, DSET, DHOLD, 0);
    wr(1, 0, 0);
    wr(2, 0, 0);
    t_sequence(21, 0, 0, 3);
    wr(1, 7, 0);
    wr(2, 2, 0);
    t_sequence(4, 7, 2, 1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R7 watchdog: actual=running expected=idle");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule